// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one DMA channel that moves items between a serial peripheral and memory. It keeps two pointer/count pairs: an active pair that the engine is consuming and a queued pair that software fills in advance. When the active count runs out and the queued count is nonzero, the queued pair moves into the active pair and the queued pair is cleared. This lets a second buffer follow the first with no software action at the boundary. The channel stops only when both counts are zero.

A parameter sets the direction. A receive channel accepts items from the peripheral on a valid/ready input stream and writes each one to memory. A transmit channel reads one item from memory and offers it to the peripheral on a valid/ready output stream. The memory request port is valid/ready. When a request is accepted, the pointer advances by 1, 2 or 4 bytes and the active count drops by one. Read data returns on a response strobe, which the channel always accepts because it has at most one read outstanding.

Back-pressure rules:
- Once `mem_req_valid` or `per_out_valid` is raised, it stays high until the matching ready is seen.
- While waiting, `per_out_data` and the read/write direction do not change.
- The request address follows the live active pointer, so a software rewrite of that pointer redirects a pending request.
- `per_in_ready` depends only on channel state, never on `per_in_valid`.

Top module: `dbuf_dma_chan`

Register map (3-bit address):
| Address | Write | Read |
|---|---|---|
| 0 | active pointer | active pointer |
| 1 | active count | remaining active count |
| 2 | queued pointer | queued pointer |
| 3 | queued count | queued count |
| 4 | control: bit0 enables, bit1 disables | status: bit0 enabled, bit1 end flag, bit2 all-done flag |
| 5 | item size | item size |

Item size codes: 0 = byte, 1 = half-word, 2 = word, 3 = word. Unlisted addresses read as zero.

## Requirements
- R1: After reset the channel is disabled. All pointers and counts read 0. Status reads 6 (end and all-done set, enable clear). No memory request, peripheral ready or peripheral valid is asserted.
- R2: Writing control bit0 enables the channel and writing bit1 disables it; disable wins if both are set. A control write of 0 changes nothing. Status bit0 shows the enable state.
- R3: A receive channel takes one item per `per_in_valid`/`per_in_ready` handshake. It then issues exactly one memory write (`mem_req_write`=1) carrying that item at the active pointer.
- R4: A transmit channel reads one item at the active pointer (`mem_req_write`=0). It then offers the returned data on `per_out_data` until the peripheral takes it, and only then fetches the next item.
- R5: Each accepted memory request advances the active pointer by 1, 2 or 4 bytes for size codes 0, 1 and 2 (code 3 acts as 4). It also decrements the active count by one.
- R6: When the active count becomes zero while the queued count is nonzero, on that same edge the queued pointer and count become active and the queued pair reads zero. The same promotion happens one cycle after software writes a nonzero queued count while the active count is zero.
- R7: Status bit1 (end flag) is set whenever the active count is zero. Status bit2 (all-done flag) is set when both counts are zero. Writing a nonzero count clears the matching flag. With both counts zero the channel issues no further requests.
- R8: If software rewrites the active pointer while a request is pending, that request and the ones after it use the new address.
- R9: No new memory request starts while the channel is disabled or the active count is zero. A receive channel holds `per_in_ready` low in that case. An item already in progress completes.
- R10: The remaining active count, and every other register, can be read at any time.
- R11: A raised `mem_req_valid` or `per_out_valid` stays high until its ready is seen. The request direction and `per_out_data` stay stable meanwhile.
- R12: A software write to a pointer or count in the same cycle as a hardware update of that register takes precedence. The other registers still take the hardware update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational on reg_addr) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_size | output | 2 | Item size code |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_rdata | input | DATA_W | Read data |
| per_in_valid | input | 1 | Peripheral item available (receive) |
| per_in_ready | output | 1 | Channel takes peripheral item |
| per_in_data | input | DATA_W | Peripheral item (receive) |
| per_out_valid | output | 1 | Item offered to peripheral (transmit) |
| per_out_ready | input | 1 | Peripheral takes item |
| per_out_data | output | DATA_W | Item to peripheral (transmit) |
| sts_end | output | 1 | Active count is zero |
| sts_all_done | output | 1 | Both counts are zero |

## Verification
On every cycle the assertions check several behaviours:
- pointer advance and count decrement on each accepted request;
- same-edge promotion of the queued pair;
- the stop when the last item of the final buffer goes;
- that no request starts while the channel is disabled or the count is zero;
- that the disable bit takes effect;
- that both outbound streams hold their valid under back-pressure.

Other behaviours only the bench scenarios can show: the full address and data sequence across a buffer switch for each item size, redirection of a stalled request by a pointer rewrite, software winning a same-cycle count update, promotion out of the idle zero state, and the transmit fetch-then-offer order.

// File: rtl/dbuf_dma_pkg.sv
package dbuf_dma_pkg;

  typedef enum logic [2:0] {
    RA_CUR_PTR = 3'd0,
    RA_CUR_CNT = 3'd1,
    RA_NXT_PTR = 3'd2,
    RA_NXT_CNT = 3'd3,
    RA_CTRL    = 3'd4,
    RA_CFG     = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_RSP  = 2'd2,
    ST_OUT  = 2'd3
  } eng_state_e;

  function automatic logic [3:0] size_step(input logic [1:0] sz);
    case (xfer_size_e'(sz))
      SZ_BYTE: size_step = 4'd1;
      SZ_HALF: size_step = 4'd2;
      default: size_step = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/dbuf_dma_bank.sv
module dbuf_dma_bank
  import dbuf_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [2:0]        sw_addr,
  input  logic [ADDR_W-1:0] sw_wdata,
  input  logic              adv,
  input  logic [3:0]        step,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [ADDR_W-1:0] nxt_ptr,
  output logic [CNT_W-1:0]  nxt_cnt
);

  logic [ADDR_W-1:0] cp_d, np_d;
  logic [CNT_W-1:0]  cc_d, nc_d;

  always_comb begin
    cp_d = cur_ptr;
    cc_d = cur_cnt;
    np_d = nxt_ptr;
    nc_d = nxt_cnt;
    // item boundary: advance the active pair
    if (adv && cur_cnt != '0) begin
      cp_d = cur_ptr + ADDR_W'(step);
      cc_d = cur_cnt - CNT_W'(1);
    end
    // promotion of the queued pair
    if (cc_d == '0 && nc_d != '0) begin
      cp_d = np_d;
      cc_d = nc_d;
      np_d = '0;
      nc_d = '0;
    end
    // software access takes precedence over hardware update
    if (sw_we) begin
      case (reg_addr_e'(sw_addr))
        RA_CUR_PTR: cp_d = sw_wdata;
        RA_CUR_CNT: cc_d = sw_wdata[CNT_W-1:0];
        RA_NXT_PTR: np_d = sw_wdata;
        RA_NXT_CNT: nc_d = sw_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ptr <= '0;
      cur_cnt <= '0;
      nxt_ptr <= '0;
      nxt_cnt <= '0;
    end else begin
      cur_ptr <= cp_d;
      cur_cnt <= cc_d;
      nxt_ptr <= np_d;
      nxt_cnt <= nc_d;
    end
  end

endmodule

// File: rtl/dbuf_dma_ctl.sv
module dbuf_dma_ctl
  import dbuf_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [2:0]        sw_addr,
  input  logic [1:0]        sw_wbits,
  input  logic [ADDR_W-1:0] cur_ptr,
  input  logic [CNT_W-1:0]  cur_cnt,
  input  logic [ADDR_W-1:0] nxt_ptr,
  input  logic [CNT_W-1:0]  nxt_cnt,
  output logic              ch_en,
  output logic [1:0]        size,
  output logic [3:0]        step,
  output logic              flag_end,
  output logic              flag_all,
  output logic [ADDR_W-1:0] rdata
);

  logic ctrl_hit, cfg_hit;

  assign ctrl_hit = sw_we && (reg_addr_e'(sw_addr) == RA_CTRL);
  assign cfg_hit  = sw_we && (reg_addr_e'(sw_addr) == RA_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_en <= 1'b0;
      size  <= SZ_BYTE;
    end else begin
      if (ctrl_hit) begin
        if (sw_wbits[1])      ch_en <= 1'b0;
        else if (sw_wbits[0]) ch_en <= 1'b1;
      end
      if (cfg_hit) size <= sw_wbits;
    end
  end

  assign step     = size_step(size);
  assign flag_end = (cur_cnt == '0);
  assign flag_all = flag_end && (nxt_cnt == '0);

  always_comb begin
    case (reg_addr_e'(sw_addr))
      RA_CUR_PTR: rdata = cur_ptr;
      RA_CUR_CNT: rdata = ADDR_W'(cur_cnt);
      RA_NXT_PTR: rdata = nxt_ptr;
      RA_NXT_CNT: rdata = ADDR_W'(nxt_cnt);
      RA_CTRL:    rdata = ADDR_W'({flag_all, flag_end, ch_en});
      RA_CFG:     rdata = ADDR_W'(size);
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/dbuf_dma_engine.sv
module dbuf_dma_engine
  import dbuf_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter bit IS_TX  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_en,
  input  logic [ADDR_W-1:0] cur_ptr,
  input  logic [CNT_W-1:0]  cur_cnt,
  input  logic [1:0]        size,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  input  logic              per_in_valid,
  output logic              per_in_ready,
  input  logic [DATA_W-1:0] per_in_data,
  output logic              per_out_valid,
  input  logic              per_out_ready,
  output logic [DATA_W-1:0] per_out_data,
  output logic              adv
);

  eng_state_e        state_q, state_d;
  logic [DATA_W-1:0] hold_q;
  logic              can_go;

  assign can_go = ch_en && (cur_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  generate
    if (IS_TX) begin : g_tx
      always_comb begin
        state_d = state_q;
        case (state_q)
          ST_IDLE: if (can_go)        state_d = ST_MEM;
          ST_MEM:  if (mem_req_ready) state_d = ST_RSP;
          ST_RSP:  if (mem_rsp_valid) state_d = ST_OUT;
          ST_OUT:  if (per_out_ready) state_d = ST_IDLE;
          default:                    state_d = ST_IDLE;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   hold_q <= '0;
        else if (state_q == ST_RSP && mem_rsp_valid)  hold_q <= mem_rsp_rdata;
      end

      assign mem_req_write = 1'b0;
      assign mem_req_wdata = '0;
      assign per_in_ready  = 1'b0;
      assign per_out_valid = (state_q == ST_OUT);
      assign per_out_data  = hold_q;
    end else begin : g_rx
      always_comb begin
        state_d = state_q;
        case (state_q)
          ST_IDLE: if (can_go && per_in_valid) state_d = ST_MEM;
          ST_MEM:  if (mem_req_ready)          state_d = ST_IDLE;
          default:                             state_d = ST_IDLE;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           hold_q <= '0;
        else if (per_in_valid && per_in_ready) hold_q <= per_in_data;
      end

      assign per_in_ready  = (state_q == ST_IDLE) && can_go;
      assign mem_req_write = 1'b1;
      assign mem_req_wdata = hold_q;
      assign per_out_valid = 1'b0;
      assign per_out_data  = '0;
    end
  endgenerate

  assign mem_req_valid = (state_q == ST_MEM);
  assign mem_req_addr  = cur_ptr;
  assign mem_req_size  = size;
  assign adv           = mem_req_valid && mem_req_ready;

endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
  import dbuf_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter bit IS_TX  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  input  logic              per_in_valid,
  output logic              per_in_ready,
  input  logic [DATA_W-1:0] per_in_data,
  output logic              per_out_valid,
  input  logic              per_out_ready,
  output logic [DATA_W-1:0] per_out_data,
  output logic              sts_end,
  output logic              sts_all_done
);

  logic [ADDR_W-1:0] cur_ptr, nxt_ptr;
  logic [CNT_W-1:0]  cur_cnt, nxt_cnt;
  logic              ch_en, adv;
  logic [1:0]        size;
  logic [3:0]        step;

  dbuf_dma_bank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .sw_we(reg_we), .sw_addr(reg_addr), .sw_wdata(reg_wdata),
    .adv(adv), .step(step),
    .cur_ptr(cur_ptr), .cur_cnt(cur_cnt),
    .nxt_ptr(nxt_ptr), .nxt_cnt(nxt_cnt)
  );

  dbuf_dma_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctl_i (
    .clk(clk), .rst_n(rst_n),
    .sw_we(reg_we), .sw_addr(reg_addr), .sw_wbits(reg_wdata[1:0]),
    .cur_ptr(cur_ptr), .cur_cnt(cur_cnt),
    .nxt_ptr(nxt_ptr), .nxt_cnt(nxt_cnt),
    .ch_en(ch_en), .size(size), .step(step),
    .flag_end(sts_end), .flag_all(sts_all_done),
    .rdata(reg_rdata)
  );

  dbuf_dma_engine #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .IS_TX(IS_TX)
  ) eng_i (
    .clk(clk), .rst_n(rst_n),
    .ch_en(ch_en), .cur_ptr(cur_ptr), .cur_cnt(cur_cnt), .size(size),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .per_in_valid(per_in_valid), .per_in_ready(per_in_ready),
    .per_in_data(per_in_data),
    .per_out_valid(per_out_valid), .per_out_ready(per_out_ready),
    .per_out_data(per_out_data),
    .adv(adv)
  );

endmodule

// File: rtl/dbuf_dma_chk.sv
module dbuf_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [ADDR_W-1:0] reg_wdata,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic              per_out_valid,
  input logic              per_out_ready,
  input logic [DATA_W-1:0] per_out_data,
  input logic              ch_en,
  input logic [ADDR_W-1:0] cur_ptr,
  input logic [CNT_W-1:0]  cur_cnt,
  input logic [ADDR_W-1:0] nxt_ptr,
  input logic [CNT_W-1:0]  nxt_cnt,
  input logic [3:0]        step
);

  // R2
  disable_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd4 && reg_wdata[1]) |=> !ch_en);

  // R5
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && cur_cnt > CNT_W'(1) && !reg_we) |=>
      (cur_ptr == $past(cur_ptr) + ADDR_W'($past(step))) &&
      (cur_cnt == $past(cur_cnt) - CNT_W'(1)));

  // R6
  promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && cur_cnt == CNT_W'(1) && nxt_cnt != '0 && !reg_we) |=>
      (cur_ptr == $past(nxt_ptr)) && (cur_cnt == $past(nxt_cnt)) &&
      (nxt_cnt == '0) && (nxt_ptr == '0));

  // R7
  final_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && cur_cnt == CNT_W'(1) && nxt_cnt == '0 && !reg_we) |=>
      (cur_cnt == '0) && (nxt_cnt == '0));

  // R9
  launch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> ($past(ch_en) && $past(cur_cnt) != '0));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_write)));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_out_valid && !per_out_ready) |=> (per_out_valid && $stable(per_out_data)));

endmodule

bind dbuf_dma_chan dbuf_dma_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .per_out_valid(per_out_valid), .per_out_ready(per_out_ready),
  .per_out_data(per_out_data),
  .ch_en(ch_en), .cur_ptr(cur_ptr), .cur_cnt(cur_cnt),
  .nxt_ptr(nxt_ptr), .nxt_cnt(nxt_cnt), .step(step)
);

// File: tb/dbuf_dma_chan_tb.sv
module dbuf_dma_chan_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // receive channel signals
  logic        rx_we = 0;
  logic [2:0]  rx_addr = 0;
  logic [31:0] rx_wdata = 0, rx_rdata;
  logic        rx_mvalid, rx_mready = 1'b1, rx_mwrite;
  logic [31:0] rx_maddr, rx_mwdata;
  logic [1:0]  rx_msize;
  logic        rx_pvalid = 0, rx_pready;
  logic [31:0] rx_pdata = 0;
  logic        rx_ovalid, rx_end, rx_all;
  logic [31:0] rx_odata;

  // transmit channel signals
  logic        tx_we = 0;
  logic [2:0]  tx_addr = 0;
  logic [31:0] tx_wdata = 0, tx_rdata;
  logic        tx_mvalid, tx_mready = 1'b1, tx_mwrite;
  logic [31:0] tx_maddr, tx_mwdata;
  logic [1:0]  tx_msize;
  logic        tx_rsp_valid = 1'b0;
  logic [31:0] tx_rsp_data = '0;
  logic        tx_pready_unused;
  logic        tx_ovalid, tx_oready = 0, tx_end, tx_all;
  logic [31:0] tx_odata;

  dbuf_dma_chan #(.IS_TX(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_we(rx_we), .reg_addr(rx_addr), .reg_wdata(rx_wdata), .reg_rdata(rx_rdata),
    .mem_req_valid(rx_mvalid), .mem_req_ready(rx_mready), .mem_req_write(rx_mwrite),
    .mem_req_addr(rx_maddr), .mem_req_size(rx_msize), .mem_req_wdata(rx_mwdata),
    .mem_rsp_valid(1'b0), .mem_rsp_rdata(32'h0),
    .per_in_valid(rx_pvalid), .per_in_ready(rx_pready), .per_in_data(rx_pdata),
    .per_out_valid(rx_ovalid), .per_out_ready(1'b0), .per_out_data(rx_odata),
    .sts_end(rx_end), .sts_all_done(rx_all)
  );

  dbuf_dma_chan #(.IS_TX(1'b1)) dut_tx_i (
    .clk(clk), .rst_n(rst_n),
    .reg_we(tx_we), .reg_addr(tx_addr), .reg_wdata(tx_wdata), .reg_rdata(tx_rdata),
    .mem_req_valid(tx_mvalid), .mem_req_ready(tx_mready), .mem_req_write(tx_mwrite),
    .mem_req_addr(tx_maddr), .mem_req_size(tx_msize), .mem_req_wdata(tx_mwdata),
    .mem_rsp_valid(tx_rsp_valid), .mem_rsp_rdata(tx_rsp_data),
    .per_in_valid(1'b0), .per_in_ready(tx_pready_unused), .per_in_data(32'h0),
    .per_out_valid(tx_ovalid), .per_out_ready(tx_oready), .per_out_data(tx_odata),
    .sts_end(tx_end), .sts_all_done(tx_all)
  );

  // memory models
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic        log_wr   [64];
  int          n_wr = 0;
  int          n_tx_wr = 0;

  always @(posedge clk) begin
    if (rx_mvalid && rx_mready) begin
      log_addr[n_wr] <= rx_maddr;
      log_data[n_wr] <= rx_mwdata;
      log_wr[n_wr]   <= rx_mwrite;
      n_wr <= n_wr + 1;
    end
    if (tx_mvalid && tx_mready && tx_mwrite) n_tx_wr <= n_tx_wr + 1;
    tx_rsp_valid <= tx_mvalid && tx_mready && !tx_mwrite;
    tx_rsp_data  <= tx_maddr ^ 32'h5A5A_0000;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit tx, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    if (tx) begin tx_we = 1; tx_addr = a; tx_wdata = d; end
    else    begin rx_we = 1; rx_addr = a; rx_wdata = d; end
    @(negedge clk);
    tx_we = 0; rx_we = 0;
  endtask

  task automatic rd(input bit tx, input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    if (tx) begin tx_addr = a; #1 v = tx_rdata; end
    else    begin rx_addr = a; #1 v = rx_rdata; end
  endtask

  task automatic rx_push(input logic [31:0] d);
    @(negedge clk);
    rx_pvalid = 1; rx_pdata = d;
    #1;
    while (!rx_pready) begin @(negedge clk); #1; end
    @(negedge clk);
    rx_pvalid = 0;
  endtask

  typedef struct packed {
    logic [1:0]  sz;
    logic [31:0] cp;
    logic [15:0] cc;
    logic [31:0] np;
    logic [15:0] nc;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{2'd2, 32'h0000_1000, 16'd3, 32'h0000_2000, 16'd2},
    '{2'd0, 32'h0000_0010, 16'd4, 32'h0000_0000, 16'd0},
    '{2'd1, 32'h0000_0300, 16'd1, 32'h0000_0400, 16'd3},
    '{2'd2, 32'h0000_FFF8, 16'd2, 32'h0000_8000, 16'd1}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(0, 3'(a), v); chk("R1 register zero", v, 32'h0);
    end
    rd(0, 3'd4, v); chk("R1 status", v, 32'h6);
    rd(1, 3'd4, v); chk("R1 tx status", v, 32'h6);
    chk("R1 no request", {31'b0, rx_mvalid | tx_mvalid}, 32'h0);
    chk("R1 no ready/valid", {30'b0, rx_pready, tx_ovalid}, 32'h0);

    // R2: enable/disable control
    wr(0, 3'd4, 32'h0); rd(0, 3'd4, v); chk("R2 write zero keeps disabled", v & 1, 32'h0);
    wr(0, 3'd4, 32'h1); rd(0, 3'd4, v); chk("R2 enable", v & 1, 32'h1);
    wr(0, 3'd4, 32'h0); rd(0, 3'd4, v); chk("R2 write zero keeps enabled", v & 1, 32'h1);
    wr(0, 3'd4, 32'h3); rd(0, 3'd4, v); chk("R2 disable wins", v & 1, 32'h0);

    // table of receive runs: R3 R5 R6 R7 R10
    for (int k = 0; k < 4; k++) begin
      int base, total;
      logic [31:0] stp, ea, fin;
      base  = n_wr;
      total = int'(VECS[k].cc) + int'(VECS[k].nc);
      stp   = (VECS[k].sz == 2'd0) ? 32'd1 : (VECS[k].sz == 2'd1) ? 32'd2 : 32'd4;
      wr(0, 3'd5, 32'(VECS[k].sz));
      wr(0, 3'd0, VECS[k].cp);
      wr(0, 3'd1, 32'(VECS[k].cc));
      wr(0, 3'd2, VECS[k].np);
      wr(0, 3'd3, 32'(VECS[k].nc));
      rd(0, 3'd1, v); chk("R10 active count readable", v, 32'(VECS[k].cc));
      wr(0, 3'd4, 32'h1);
      for (int i = 0; i < total; i++) rx_push(32'hD000_0000 + 32'(k * 256 + i));
      repeat (3) @(negedge clk);
      chk("R3 one write per item", 32'(n_wr - base), 32'(total));
      for (int i = 0; i < total; i++) begin
        if (i < int'(VECS[k].cc)) ea = VECS[k].cp + 32'(i) * stp;
        else                      ea = VECS[k].np + 32'(i - int'(VECS[k].cc)) * stp;
        chk("R5 R6 write address", log_addr[base + i], ea);
        chk("R3 write data", log_data[base + i], 32'hD000_0000 + 32'(k * 256 + i));
        chk("R3 write direction", {31'b0, log_wr[base + i]}, 32'h1);
      end
      fin = (VECS[k].nc != 0) ? VECS[k].np + 32'(VECS[k].nc) * stp
                              : VECS[k].cp + 32'(VECS[k].cc) * stp;
      rd(0, 3'd0, v); chk("R5 final pointer", v, fin);
      rd(0, 3'd3, v); chk("R6 queued count cleared", v, 32'h0);
      rd(0, 3'd2, v); chk("R6 queued pointer cleared", v, 32'h0);
      rd(0, 3'd4, v); chk("R7 status when exhausted", v, 32'h7);
      // R7: no further requests with both counts zero
      @(negedge clk); rx_pvalid = 1; #1;
      chk("R7 stopped", {31'b0, rx_pready}, 32'h0);
      repeat (3) @(negedge clk);
      rx_pvalid = 0;
      chk("R7 no extra write", 32'(n_wr - base), 32'(total));
      wr(0, 3'd4, 32'h2);
    end

    // R9: disabled channel with a count takes nothing
    wr(0, 3'd0, 32'h500); wr(0, 3'd1, 32'd2);
    rd(0, 3'd4, v); chk("R7 nonzero count clears flags", v, 32'h0);
    begin
      int b;
      b = n_wr;
      @(negedge clk); rx_pvalid = 1;
      for (int c = 0; c < 4; c++) begin
        #1 chk("R9 disabled holds ready low", {31'b0, rx_pready}, 32'h0);
        @(negedge clk);
      end
      rx_pvalid = 0;
      wr(0, 3'd1, 32'd0); wr(0, 3'd4, 32'h1);
      @(negedge clk); rx_pvalid = 1; #1;
      chk("R9 zero count holds ready low", {31'b0, rx_pready}, 32'h0);
      repeat (3) @(negedge clk);
      rx_pvalid = 0;
      chk("R9 no write", 32'(n_wr - b), 32'h0);
    end

    // R8 R11 R12: stalled request, pointer rewrite, collision
    wr(0, 3'd5, 32'd2); wr(0, 3'd0, 32'h600); wr(0, 3'd1, 32'd5);
    rx_mready = 0;
    rx_push(32'hCAFE_0001);
    #1 chk("R11 request raised", {31'b0, rx_mvalid}, 32'h1);
    chk("R3 request address", rx_maddr, 32'h600);
    repeat (2) @(negedge clk);
    #1 chk("R11 request held", {31'b0, rx_mvalid}, 32'h1);
    wr(0, 3'd0, 32'h700);
    #1 chk("R8 redirected address", rx_maddr, 32'h700);
    @(negedge clk);
    rx_mready = 1; rx_we = 1; rx_addr = 3'd1; rx_wdata = 32'd9;
    @(negedge clk);
    rx_we = 0;
    rd(0, 3'd1, v); chk("R12 software count wins", v, 32'd9);
    rd(0, 3'd0, v); chk("R12 pointer still advances", v, 32'h704);
    chk("R8 write used new address", log_addr[n_wr - 1], 32'h700);
    wr(0, 3'd4, 32'h2);

    // R6: promotion from idle zero state
    wr(0, 3'd1, 32'd0);
    wr(0, 3'd2, 32'h900); wr(0, 3'd3, 32'd2);
    rd(0, 3'd1, v); chk("R6 idle promote count", v, 32'd2);
    rd(0, 3'd0, v); chk("R6 idle promote pointer", v, 32'h900);
    rd(0, 3'd3, v); chk("R6 idle promote clears queue", v, 32'h0);

    // R4: transmit channel fetch then offer
    wr(1, 3'd5, 32'd1); wr(1, 3'd0, 32'h40); wr(1, 3'd1, 32'd3); wr(1, 3'd4, 32'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      while (!tx_ovalid) begin @(negedge clk); #1; end
      chk("R4 offered data", tx_odata, (32'h40 + 32'(2 * i)) ^ 32'h5A5A_0000);
      if (i == 0) begin
        repeat (3) @(negedge clk);
        #1 chk("R11 output held", {31'b0, tx_ovalid}, 32'h1);
        chk("R11 output data stable", tx_odata, 32'h5A5A_0040);
        chk("R4 one fetch outstanding", {31'b0, tx_mvalid}, 32'h0);
      end
      tx_oready = 1;
      @(negedge clk);
      tx_oready = 0;
    end
    repeat (4) @(negedge clk);
    #1 chk("R4 no fourth offer", {31'b0, tx_ovalid}, 32'h0);
    chk("R4 read direction only", 32'(n_tx_wr), 32'h0);
    rd(1, 3'd0, v); chk("R5 tx pointer half steps", v, 32'h46);
    rd(1, 3'd4, v); chk("R7 tx status", v, 32'h7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule